// File: doc/BRIEF.md
# E4M3 Byte to Half/Single Precision Expander

This block widens one 8-bit floating-point byte in the E4M3 layout to either IEEE half precision or IEEE single precision. The byte has one sign bit, a 4-bit exponent with bias 7 and a 3-bit fraction. The format has no infinity code, so its largest finite magnitude is 448. The exponent and fraction codes that are all ones together form the only NaN. Every E4M3 value can be represented exactly in both wider formats, so the conversion never rounds.

A format-select input picks the output width for each beat. Normal codes are rebiased with a shift and a constant add. Codes whose exponent field is zero (zero and the seven subnormals) are taken from an 8-entry table. The NaN code is replaced by a canonical quiet NaN. The input sign is ORed in last, so negative zero and negative NaN keep their sign. One register stage holds the result together with a valid flag.

Top module: `e4m3_expander`

## Requirements
- R1: With fmt_sel=0, for a code with exponent field e (bits 6:3) in 1..15 and fraction f (bits 2:0) that is not NaN, out_data[14:10] equals e+8 and out_data[9:7] equals f, with bits 6:0 zero. For example 0x7E gives 0x5F00 (448).
- R2: With fmt_sel=1, for the same normal codes, out_data[30:23] equals e+120, out_data[22:20] equals f, and bits 19:0 are zero. For example 0x7E gives 0x43E00000.
- R3: With fmt_sel=0, a code whose bits 6:0 equal 0x7F produces 0x7E00, or 0xFE00 when bit 7 is set.
- R4: With fmt_sel=1, a code whose bits 6:0 equal 0x7F produces 0x7FC00000, or 0xFFC00000 when bit 7 is set.
- R5: With fmt_sel=0, magnitudes 0x00 through 0x07 produce, in that order, 0x0000, 0x1800, 0x1C00, 0x1E00, 0x2000, 0x2100, 0x2200 and 0x2300, each the exact value f·2^-9.
- R6: With fmt_sel=1, magnitudes 0x00 through 0x07 produce, in that order, 0x00000000, 0x3B000000, 0x3B800000, 0x3BC00000, 0x3C000000, 0x3C200000, 0x3C400000 and 0x3C600000.
- R7: The sign bit of the selected result (bit 15 for half, bit 31 for single) equals input bit 7 for every code, including negative zero (0x80 gives 0x8000 or 0x80000000).
- R8: fmt_sel=0 selects half precision in out_data[15:0] with out_data[31:16] zero. fmt_sel=1 selects single precision across all 32 bits.
- R9: out_valid equals in_valid delayed by one clock, and out_data shows the result of the code presented with in_valid one clock earlier. A synchronous active-low reset clears out_valid and out_data to zero.
- R10: A cycle with in_valid low leaves out_data unchanged on the next clock, whatever in_code and fmt_sel carry.
- R11: Re-encoding any non-NaN result to E4M3 gives back the original byte exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | in_code and fmt_sel carry a value to convert |
| in_code | input | 8 | E4M3 byte: sign bit 7, exponent 6:3, fraction 2:0 |
| fmt_sel | input | 1 | 0 selects half precision output, 1 selects single precision |
| out_valid | output | 1 | out_data holds a fresh result |
| out_data | output | 32 | Widened value, half precision right-aligned with upper half zero |

## Verification
The block holds state only in its output register and its valid flag. A fault there therefore shows at the ports on the first clock after the beat that exposes it. A bad table entry or a wrong bias offset corrupts exactly the codes that use that entry or path, so the bench sweeps all 256 codes in both formats and catches any such fault within one sweep. A valid flag that is stuck or delayed shows on the cycle that follows a gap. A data register that loads when it should not shows in the hold check made at each inserted gap.

// File: rtl/e4m3_pkg.sv
// Package: shared field layout, format encoding and derived constants for
// the E4M3 expander. Assumes IEEE half and single precision targets.
package e4m3_pkg;

    localparam int SRC_EXP_W  = 4;
    localparam int SRC_MAN_W  = 3;
    localparam int SRC_BIAS   = 7;
    localparam int HALF_MAN_W = 10;
    localparam int HALF_BIAS  = 15;
    localparam int SNGL_MAN_W = 23;
    localparam int SNGL_BIAS  = 127;
    localparam int SRC_W      = 1 + SRC_EXP_W + SRC_MAN_W;
    localparam int MAG_W      = SRC_W - 1;
    localparam int TINY_N     = 1 << SRC_MAN_W;

    // Exponent offsets between source and target biases.
    localparam int HALF_OFS = HALF_BIAS - SRC_BIAS;
    localparam int SNGL_OFS = SNGL_BIAS - SRC_BIAS;

    localparam logic [15:0] HALF_QNAN = 16'h7E00;
    localparam logic [31:0] SNGL_QNAN = 32'h7FC0_0000;

    typedef enum logic {
        FMT_HALF   = 1'b0,
        FMT_SINGLE = 1'b1
    } fmt_e;

    typedef struct packed {
        logic                 sgn;
        logic [SRC_EXP_W-1:0] exp;
        logic [SRC_MAN_W-1:0] man;
    } e4m3_t;

    // Exact target encoding of magnitude m * 2^-(BIAS-1+MAN_W), m < TINY_N.
    function automatic logic [31:0] tiny_entry(input int m, input bit single);
        int sig;
        int p;
        int e;
        logic [31:0] r;
        sig = m;
        p   = -(SRC_BIAS - 1 + SRC_MAN_W);
        r   = '0;
        if (m != 0) begin
            for (int k = 0; k < SRC_MAN_W; k++) begin
                if (sig < TINY_N) begin
                    sig = sig << 1;
                    p   = p - 1;
                end
            end
            if (single) begin
                e = p + SRC_MAN_W + SNGL_BIAS;
                r = (32'(e) << SNGL_MAN_W) | (32'(sig - TINY_N) << (SNGL_MAN_W - SRC_MAN_W));
            end else begin
                e = p + SRC_MAN_W + HALF_BIAS;
                r = (32'(e) << HALF_MAN_W) | (32'(sig - TINY_N) << (HALF_MAN_W - SRC_MAN_W));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/e4m3_tiny_lut.sv
// Module: table of exact target encodings for codes whose exponent field is
// zero. Entries are computed at elaboration; index is the fraction field.
// Assumes OUT_W matches the target selected by SINGLE (16 or 32).
module e4m3_tiny_lut
    import e4m3_pkg::*;
#(
    parameter int OUT_W  = 16,
    parameter bit SINGLE = 1'b0
) (
    input  logic [SRC_MAN_W-1:0] man,
    output logic [OUT_W-1:0]     mag
);

    logic [OUT_W-1:0] tbl [TINY_N];

    // One constant entry per fraction value.
    for (genvar i = 0; i < TINY_N; i++) begin : g_ent
        localparam logic [31:0] ENT = tiny_entry(i, SINGLE);
        assign tbl[i] = ENT[OUT_W-1:0];
    end

    // Select the entry addressed by the fraction.
    assign mag = tbl[man];

endmodule

// File: rtl/e4m3_normal_path.sv
// Module: rebias of normal E4M3 magnitudes into both target widths.
// Half path shifts the byte into place and adds a bias offset; single path
// widens the exponent and adds its offset. Sign is not handled here.
module e4m3_normal_path
    import e4m3_pkg::*;
(
    input  logic [MAG_W-1:0] mag,
    output logic [15:0]      half_mag,
    output logic [31:0]      sngl_mag
);

    localparam logic [15:0] HALF_ADD = 16'(HALF_OFS) << HALF_MAN_W;
    localparam logic [7:0]  SNGL_ADD = 8'(SNGL_OFS);

    logic [15:0] half_word;
    logic [7:0]  sngl_exp;

    // Half: magnitude in the high byte, shifted right by one, bias added.
    always_comb begin
        half_word = {1'b0, mag, 8'h00} >> 1;
        half_mag  = half_word + HALF_ADD;
    end

    // Single: exponent widened and offset, fraction left-aligned.
    always_comb begin
        sngl_exp = {4'b0000, mag[MAG_W-1 -: SRC_EXP_W]} + SNGL_ADD;
        sngl_mag = {1'b0, sngl_exp, mag[SRC_MAN_W-1:0], 20'h00000};
    end

endmodule

// File: rtl/e4m3_out_stage.sv
// Module: output register with valid. Data loads only on a valid beat;
// synchronous active-low reset clears both valid and data.
module e4m3_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    // Register the beat; hold data through idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_data <= d_data;
            end
        end
    end

endmodule

// File: rtl/e4m3_expander.sv
// Module: top of the E4M3 widening decoder. Chooses between normal rebias,
// the zero-exponent table and canonical NaN, ORs the input sign in last,
// and registers the result. Assumes in_code is stable while in_valid is high.
module e4m3_expander
    import e4m3_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_code,
    input  logic        fmt_sel,
    output logic        out_valid,
    output logic [31:0] out_data
);

    e4m3_t            code;
    logic [MAG_W-1:0] mag;
    logic             is_nan;
    logic             is_tiny;
    logic [15:0]      half_norm;
    logic [31:0]      sngl_norm;
    logic [15:0]      half_tiny;
    logic [31:0]      sngl_tiny;
    logic [15:0]      half_res;
    logic [31:0]      sngl_res;
    logic [31:0]      next_data;
    fmt_e             fmt;

    assign code = e4m3_t'(in_code);
    assign mag  = {code.exp, code.man};
    assign fmt  = fmt_e'(fmt_sel);

    // Classify the incoming magnitude.
    always_comb begin
        is_nan  = &mag;
        is_tiny = (code.exp == '0);
    end

    e4m3_normal_path u_norm (
        .mag      (mag),
        .half_mag (half_norm),
        .sngl_mag (sngl_norm)
    );

    e4m3_tiny_lut #(.OUT_W(16), .SINGLE(1'b0)) u_lut_half (
        .man (code.man),
        .mag (half_tiny)
    );

    e4m3_tiny_lut #(.OUT_W(32), .SINGLE(1'b1)) u_lut_sngl (
        .man (code.man),
        .mag (sngl_tiny)
    );

    // Pick the magnitude per case, then OR in the sign.
    always_comb begin
        if (is_nan)       half_res = HALF_QNAN;
        else if (is_tiny) half_res = half_tiny;
        else              half_res = half_norm;
        half_res[15] = half_res[15] | code.sgn;

        if (is_nan)       sngl_res = SNGL_QNAN;
        else if (is_tiny) sngl_res = sngl_tiny;
        else              sngl_res = sngl_norm;
        sngl_res[31] = sngl_res[31] | code.sgn;
    end

    // Route the selected width onto the output word.
    always_comb begin
        if (fmt == FMT_SINGLE) next_data = sngl_res;
        else                   next_data = {16'h0000, half_res};
    end

    e4m3_out_stage #(.W(32)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d_data  (next_data),
        .q_valid (out_valid),
        .q_data  (out_data)
    );

endmodule

// File: rtl/e4m3_expander_chk.sv
// Module: temporal checks on the expander ports, bound to every instance.
module e4m3_expander_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  in_code,
    input logic        fmt_sel,
    input logic        out_valid,
    input logic [31:0] out_data
);

    assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(out_data));

    assert_half_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(in_code[6:0]) == 7'h7F) && !$past(fmt_sel))
        |-> (out_data == {16'h0000, $past(in_code[7]), 15'h7E00}));

    assert_sngl_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(in_code[6:0]) == 7'h7F) && $past(fmt_sel))
        |-> (out_data == {$past(in_code[7]), 31'h7FC0_0000}));

    assert_sign_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (($past(fmt_sel) ? out_data[31] : out_data[15]) == $past(in_code[7])));

    assert_half_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(fmt_sel)) |-> (out_data[31:16] == 16'h0000));

endmodule

bind e4m3_expander e4m3_expander_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .fmt_sel   (fmt_sel),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_e4m3_expander.sv
module sim_e4m3_expander;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_code;
    logic        fmt_sel;
    logic        out_valid;
    logic [31:0] out_data;

    int n_chk;
    int n_bad;
    bit done;

    e4m3_expander u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .fmt_sel   (fmt_sel),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Expected encoding from the value sig*2^p, normalised arithmetically.
    function automatic logic [31:0] model(input logic [7:0] b, input bit single);
        int e;
        int f;
        int sig;
        int p;
        int te;
        logic [31:0] r;
        e = int'(b[6:3]);
        f = int'(b[2:0]);
        if (b[6:0] == 7'h7F) begin
            r = single ? 32'h7FC00000 : 32'h00007E00;
        end else begin
            sig = (e == 0) ? f : 8 + f;
            p   = (e == 0) ? -9 : e - 10;
            if (sig == 0) begin
                r = 32'h0;
            end else begin
                while (sig < 8) begin
                    sig = sig * 2;
                    p   = p - 1;
                end
                if (single) begin
                    te = p + 3 + 127;
                    r = (32'(te) << 23) | (32'(sig - 8) << 20);
                end else begin
                    te = p + 3 + 15;
                    r = (32'(te) << 10) | (32'(sig - 8) << 7);
                end
            end
        end
        if (b[7]) r = r | (single ? 32'h80000000 : 32'h00008000);
        return r;
    endfunction

    // Independent re-encoding of a non-NaN wide value back to E4M3.
    function automatic logic [7:0] reenc(input logic [31:0] v, input bit single);
        int te;
        int f;
        int u;
        logic s;
        logic [6:0] m;
        if (single) begin
            te = int'(v[30:23]); f = int'(v[22:20]); u = te - 127; s = v[31];
        end else begin
            te = int'(v[14:10]); f = int'(v[9:7]);  u = te - 15;  s = v[15];
        end
        if (te == 0 && f == 0)  m = 7'h00;
        else if (u >= -6)       m = 7'((u + 7) * 8 + f);
        else                    m = 7'((8 + f) >> (-6 - u));
        return {s, m};
    endfunction

    initial begin
        n_chk = 0;
        n_bad = 0;
        done = 1'b0;
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_code = 8'h7F;
        fmt_sel = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 reset valid", {31'h0, out_valid}, 32'h0);
        check(out_data == 32'h0, "R9 reset data", out_data, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 idle after reset", {31'h0, out_valid}, 32'h0);

        for (int fm = 0; fm < 2; fm++) begin
            for (int c = 0; c < 256; c++) begin
                logic [7:0]  b;
                logic [31:0] exp_v;
                logic [31:0] held;
                bit          sg;
                b = 8'(c);
                sg = (fm == 1);
                in_valid = 1'b1;
                in_code  = b;
                fmt_sel  = sg;
                @(negedge clk);
                exp_v = model(b, sg);
                check(out_valid == 1'b1, "R9 valid delay", {31'h0, out_valid}, 32'h1);
                if (b[6:0] == 7'h7F)
                    check(out_data == exp_v, sg ? "R4 nan single" : "R3 nan half", out_data, exp_v);
                else if (b[6:3] == 4'h0)
                    check(out_data == exp_v, sg ? "R6 tiny single" : "R5 tiny half", out_data, exp_v);
                else
                    check(out_data == exp_v, sg ? "R2 normal single" : "R1 normal half", out_data, exp_v);
                check((sg ? out_data[31] : out_data[15]) == b[7], "R7 sign", out_data, exp_v);
                if (!sg)
                    check(out_data[31:16] == 16'h0, "R8 half upper zero", out_data, exp_v);
                if (b[6:0] != 7'h7F)
                    check(reenc(out_data, sg) == b, "R11 round trip",
                          {24'h0, reenc(out_data, sg)}, {24'h0, b});
                if (c % 17 == 5) begin
                    held = out_data;
                    in_valid = 1'b0;
                    in_code  = ~b;
                    fmt_sel  = ~sg;
                    @(negedge clk);
                    check(out_valid == 1'b0, "R9 gap valid", {31'h0, out_valid}, 32'h0);
                    check(out_data == held, "R10 idle hold", out_data, held);
                end
            end
        end

        // R1/R2 boundary: largest finite magnitude 448
        in_valid = 1'b1; in_code = 8'h7E; fmt_sel = 1'b0;
        @(negedge clk);
        check(out_data == 32'h00005F00, "R1 max finite half", out_data, 32'h00005F00);
        in_code = 8'h7E; fmt_sel = 1'b1;
        @(negedge clk);
        check(out_data == 32'h43E00000, "R2 max finite single", out_data, 32'h43E00000);
        // R7: negative zero in both widths
        in_code = 8'h80; fmt_sel = 1'b0;
        @(negedge clk);
        check(out_data == 32'h00008000, "R7 neg zero half", out_data, 32'h00008000);
        in_code = 8'h80; fmt_sel = 1'b1;
        @(negedge clk);
        check(out_data == 32'h80000000, "R7 neg zero single", out_data, 32'h80000000);
        // R9: reset mid-stream clears data
        rst_n = 1'b0;
        @(negedge clk);
        check(out_data == 32'h0 && out_valid == 1'b0, "R9 reset clears", out_data, 32'h0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule